// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave end of the serial command port of a small flash memory. The host frames each operation with an active-low select. While selected, the host shifts an 8-bit opcode in on the serial clock, most significant bit first. Depending on the opcode, a 24-bit address or a protection data field follows. Read commands return a byte on a serial output, which is presented as a data bit and an output-enable pair that drive a pad tri-state buffer.

Program and erase requests pass through two gates before they start a self-timed busy period, which stands in for the cell timing. The first gate is an active-low hardware write-protect input. The second is a small sector protection register, a protection enable flag and permanent per-sector lock bits. All inputs are sampled in the system clock domain, and serial clock edges are detected against the previous sample. An active-low reset aborts any command or busy period and clears the protection state.

Top module: `sflash_cmd_front`

## Requirements
- R1: After reset, soOe and busy are 0, standby is 1, and a status read returns 0x80.
- R2: While csN is high, transitions on sck and si change nothing, and soOe stays 0.
- R3: Every falling edge of csN restarts opcode framing. A frame cut short by csN rising leaves no effect on the next frame.
- R4: Read data leaves on soData MSB first and changes after each sck fall. soOe is high from the first fall after the opcode until csN rises. Status read (0x05) returns bit7 = not busy and bit0 = protection enabled, with all other bits 0. Protection read (0x35) returns the 8-bit sector protection register.
- R5: Program (0x02) and erase (0x20) take a 24-bit address, and the sector is address bits 23:21. When accepted, busy rises after csN rises and stays high for exactly BUSY_CYCLES clock cycles.
- R6: A program or erase opcode that completes while wpN is low starts no busy period.
- R7: Protection write (0x4E) takes 8 data bits; bit k protects sector k. The write is refused while wpN is low.
- R8: Protection enable (0x3A) and sector lockdown (0x7C followed by a 24-bit address) are accepted while wpN is low.
- R9: A program or erase is dropped when its sector is locked, or when protection is enabled and the sector's bit in the protection register is set.
- R10: While rstN is low, busy is cleared, soOe is 0 and no command is executed.
- R11: standby is 1 only when csN is high and no busy period runs. It stays 0 after csN rises until busy ends.
- R12: While busy, every opcode except status read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data in |
| wpN | input | 1 | Active-low hardware write protect |
| soData | output | 1 | Serial read data bit |
| soOe | output | 1 | Output enable for the serial data pad |
| busy | output | 1 | Self-timed operation running |
| standby | output | 1 | Deselected and idle |

## Verification
Each serial clock edge acts at the first system clock edge after it. The bench holds every sck level for four clock cycles and samples one to four cycles after each edge. It reads soData just before the sck rise that would move it, so every bit has settled after the preceding fall.

busy rises one cycle after the select rise is seen. The bench starts counting on the negative clock edge right after it drives csN high, so the count of busy samples must equal BUSY_CYCLES exactly. The protection sweeps run every sector against two patterns, and the bench computes acceptance from the register value, the enable flag and the lock bits.

// File: rtl/sfcfe_pkg.sv
package sfcfe_pkg;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_PROT_RD = 8'h35;
  localparam logic [7:0] OP_PROG    = 8'h02;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROT_EN = 8'h3A;
  localparam logic [7:0] OP_LOCK    = 8'h7C;
  localparam logic [7:0] OP_PROT_WR = 8'h4E;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DATA, S_READ, S_ARMED, S_DROP
  } state_t;

  typedef enum logic {LD_STATUS, LD_PROT} ldSel_t;

  typedef struct packed {
    logic   shiftIn;
    logic   outLoad;
    ldSel_t outSel;
    logic   outStep;
    logic   outClear;
    logic   protEnSet;
    logic   lockSet;
    logic   protWrite;
    logic   startOp;
  } strobe_t;
endpackage

// File: rtl/sfcfe_ctrl.sv
module sfcfe_ctrl
  import sfcfe_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SECT_W = 3,
  parameter int NSECT  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              wpN,
  input  logic              busy,
  input  logic [7:0]        rxByte,
  input  logic [SECT_W-1:0] rxSect,
  input  logic [NSECT-1:0]  blockMask,
  output strobe_t           stb,
  output logic              standby
);
  localparam int CNT_W = $clog2(ADDR_W);

  state_t state, stateN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic [7:0] opReg, opN;
  logic sckQ, csQ;

  wire sckRise = sck & ~sckQ & ~csN;
  wire sckFall = ~sck & sckQ & ~csN;
  wire csFall  = ~csN & csQ;
  wire csRise  = csN & ~csQ;

  always_comb begin
    stb    = '0;
    stateN = state;
    cntN   = bitCnt;
    opN    = opReg;
    if (csRise) begin
      stb.outClear = 1'b1;
      stb.startOp  = (state == S_ARMED);
      stateN       = S_IDLE;
    end else if (csFall) begin
      stb.outClear = 1'b1;
      stateN       = S_CMD;
      cntN         = '0;
    end else begin
      case (state)
        S_CMD: if (sckRise) begin
          stb.shiftIn = 1'b1;
          cntN        = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(7)) begin
            cntN   = '0;
            opN    = rxByte;
            stateN = S_DROP;
            if (!busy || rxByte == OP_STATUS) begin
              case (rxByte)
                OP_STATUS:  begin stb.outLoad = 1'b1; stb.outSel = LD_STATUS; stateN = S_READ; end
                OP_PROT_RD: begin stb.outLoad = 1'b1; stb.outSel = LD_PROT;   stateN = S_READ; end
                OP_PROG, OP_ERASE: stateN = wpN ? S_ADDR : S_DROP;
                OP_LOCK:    stateN = S_ADDR;
                OP_PROT_EN: stb.protEnSet = 1'b1;
                OP_PROT_WR: stateN = wpN ? S_DATA : S_DROP;
                default:    stateN = S_DROP;
              endcase
            end
          end
        end
        S_ADDR: if (sckRise) begin
          stb.shiftIn = 1'b1;
          cntN        = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(ADDR_W - 1)) begin
            if (opReg == OP_LOCK) begin
              stb.lockSet = 1'b1;
              stateN      = S_DROP;
            end else begin
              stateN = blockMask[rxSect] ? S_DROP : S_ARMED;
            end
          end
        end
        S_DATA: if (sckRise) begin
          stb.shiftIn = 1'b1;
          cntN        = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(NSECT - 1)) begin
            stb.protWrite = 1'b1;
            stateN        = S_DROP;
          end
        end
        S_READ:  stb.outStep = sckFall;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      opReg   <= '0;
      sckQ    <= 1'b0;
      csQ     <= 1'b1;
      standby <= 1'b1;
    end else begin
      state   <= stateN;
      bitCnt  <= cntN;
      opReg   <= opN;
      sckQ    <= sck;
      csQ     <= csN;
      standby <= csN & ~busy & (state != S_ARMED);
    end
  end

  // R10: the control sequencer sits in idle for every cycle reset is held
  p_reset_idle_r10: assert property (@(posedge clk) !rstN |-> state == S_IDLE);

  // R11: a running busy period keeps standby low on the following cycle
  p_standby_deferred_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !standby);
endmodule

// File: rtl/sfcfe_datapath.sv
module sfcfe_datapath
  import sfcfe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SECT_W      = 3,
  parameter int NSECT       = 8,
  parameter int BUSY_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              si,
  input  logic              wpN,
  input  strobe_t           stb,
  output logic [7:0]        rxByte,
  output logic [SECT_W-1:0] rxSect,
  output logic [NSECT-1:0]  blockMask,
  output logic              busy,
  output logic              soData,
  output logic              soOe
);
  localparam int OUT_W  = (NSECT > 8) ? NSECT : 8;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [ADDR_W-2:0] inShift;
  logic [NSECT-1:0]  protReg, lockBits;
  logic              protEn;
  logic [BUSY_W-1:0] busyCnt;
  logic [OUT_W-1:0]  outShift;
  logic              outValid;

  wire [SECT_W-1:0] lockSect  = inShift[ADDR_W-2 -: SECT_W];
  wire [NSECT-1:0]  wrData    = {inShift[NSECT-2:0], si};
  wire [7:0]        statusVal = {~busy, 6'b0, protEn};

  assign rxByte    = {inShift[6:0], si};
  assign rxSect    = lockSect;
  assign blockMask = lockBits | (protEn ? protReg : '0);
  assign busy      = (busyCnt != '0);
  assign soData    = outShift[OUT_W-1];
  assign soOe      = outValid & ~csN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      protReg  <= '0;
      lockBits <= '0;
      protEn   <= 1'b0;
      busyCnt  <= '0;
      outShift <= '0;
      outValid <= 1'b0;
    end else begin
      if (stb.shiftIn) inShift <= {inShift[ADDR_W-3:0], si};
      if (stb.protEnSet) protEn <= 1'b1;
      if (stb.lockSet) lockBits[lockSect] <= 1'b1;
      if (stb.protWrite && wpN) protReg <= wrData;
      if (stb.startOp) busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
      if (stb.outClear) begin
        outValid <= 1'b0;
      end else if (stb.outLoad) begin
        outValid <= 1'b0;
        outShift <= (stb.outSel == LD_STATUS) ? (OUT_W'(statusVal) << (OUT_W - 8))
                                              : (OUT_W'(protReg) << (OUT_W - NSECT));
      end else if (stb.outStep) begin
        if (!outValid) outValid <= 1'b1;
        else outShift <= {outShift[OUT_W-2:0], 1'b0};
      end
    end
  end

  // R2: a deselected port never leaves read data enabled
  p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !outValid);

  // R5: a busy period only begins from a start strobe
  p_busy_from_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stb.startOp));

  // R7: the protection register holds while write protect is low
  p_prot_hold_wp_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wpN) |-> $stable(protReg));
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfcfe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SECT_W      = 3,
  parameter int BUSY_CYCLES = 4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic wpN,
  output logic soData,
  output logic soOe,
  output logic busy,
  output logic standby
);
  localparam int NSECT = 1 << SECT_W;

  strobe_t           stb;
  logic [7:0]        rxByte;
  logic [SECT_W-1:0] rxSect;
  logic [NSECT-1:0]  blockMask;

  sfcfe_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .NSECT(NSECT)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .wpN(wpN), .busy(busy),
    .rxByte(rxByte), .rxSect(rxSect), .blockMask(blockMask),
    .stb(stb), .standby(standby)
  );

  sfcfe_datapath #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .NSECT(NSECT),
                   .BUSY_CYCLES(BUSY_CYCLES)) uData (
    .clk(clk), .rstN(rstN), .csN(csN), .si(si), .wpN(wpN), .stb(stb),
    .rxByte(rxByte), .rxSect(rxSect), .blockMask(blockMask), .busy(busy),
    .soData(soData), .soOe(soOe)
  );
endmodule

// File: tb/tb_sflash_cmd_front.sv
module tb_sflash_cmd_front;
  import sfcfe_pkg::*;
  localparam int BUSY = 400;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0, wpN = 1'b1;
  logic soData, soOe, busy, standby;
  int nChecks = 0, nBad = 0;

  always #10 clk = ~clk;

  sflash_cmd_front #(.ADDR_W(24), .SECT_W(3), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .wpN(wpN),
    .soData(soData), .soOe(soOe), .busy(busy), .standby(standby));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic sel();   csN = 1'b0; tick(3); endtask
  task automatic desel(); csN = 1'b1; tick(3); endtask

  task automatic sendBits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      si = v[i]; tick(2); sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    end
  endtask

  task automatic readBits(output logic [7:0] v, output logic oeOk);
    oeOk = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      v[i] = soData;
      if (!soOe) oeOk = 1'b0;
      sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    end
  endtask

  task automatic readCmd(logic [7:0] op, output logic [7:0] v, output logic oeOk);
    sel(); sendBits(32'(op), 8); readBits(v, oeOk); desel();
  endtask

  task automatic writeProt(logic [7:0] d);
    sel(); sendBits(32'(OP_PROT_WR), 8); sendBits(32'(d), 8); desel();
  endtask

  task automatic peCmd(logic [7:0] op, logic [23:0] a, output int len, output int stbyBad,
                       output logic stbyAfter);
    len = 0; stbyBad = 0;
    sel(); sendBits(32'(op), 8); sendBits(32'(a), 24);
    csN = 1'b1;
    for (int t = 0; t < BUSY + 200; t++) begin
      tick(1);
      if (busy) begin len++; if (standby) stbyBad++; end
    end
    stbyAfter = standby;
  endtask

  task automatic waitIdle();
    for (int t = 0; t < 2000 && busy; t++) tick(1);
    tick(2);
  endtask

  logic [7:0] rd;
  logic oe, sAfter;
  int len, sBad;
  logic [7:0] pat;

  initial begin
    tick(4); rstN = 1'b1; tick(2);
    chk("R1 soOe", 32'(soOe), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 standby", 32'(standby), 1);
    readCmd(OP_STATUS, rd, oe);
    chk("R1 status", 32'(rd), 32'h80);
    chk("R4 soOe during read", 32'(oe), 1);
    chk("R4 soOe after deselect", 32'(soOe), 0);
    readCmd(OP_PROT_RD, rd, oe);
    chk("R7 prot reset value", 32'(rd), 0);
    writeProt(8'hA5);
    readCmd(OP_PROT_RD, rd, oe);
    chk("R7 prot write accepted", 32'(rd), 32'hA5);

    // R2: traffic with select high
    sendBits({16'h0, OP_PROT_WR, 8'h3C}, 16);
    chk("R2 soOe deselected", 32'(soOe), 0);
    readCmd(OP_PROT_RD, rd, oe);
    chk("R2 prot unchanged", 32'(rd), 32'hA5);

    // R3: truncated frames
    sel(); sendBits(32'h5, 3); desel();
    readCmd(OP_STATUS, rd, oe);
    chk("R3 status after cut frame", 32'(rd), 32'h80);
    sel(); sendBits(32'(OP_PROT_WR >> 3), 5); desel();
    readCmd(OP_PROT_RD, rd, oe);
    chk("R3 prot after cut frame", 32'(rd), 32'hA5);

    // R5 / R11: plain program
    peCmd(OP_PROG, 24'h123456, len, sBad, sAfter);
    chk("R5 busy length", 32'(len), 32'(BUSY));
    chk("R11 standby while busy", 32'(sBad), 0);
    chk("R11 standby after busy", 32'(sAfter), 1);

    // R12 / R4: commands while busy
    sel(); sendBits(32'(OP_ERASE), 8); sendBits(32'h0, 24); desel();
    chk("R5 busy after erase", 32'(busy), 1);
    readCmd(OP_STATUS, rd, oe);
    chk("R4 status while busy", 32'(rd), 0);
    writeProt(8'h11);
    chk("R12 still busy", 32'(busy), 1);
    waitIdle();
    readCmd(OP_PROT_RD, rd, oe);
    chk("R12 prot write ignored while busy", 32'(rd), 32'hA5);

    // R6 / R7 / R8: hardware write protect
    wpN = 1'b0;
    peCmd(OP_PROG, 24'h000010, len, sBad, sAfter);
    chk("R6 program dropped", 32'(len), 0);
    peCmd(OP_ERASE, 24'hE00000, len, sBad, sAfter);
    chk("R6 erase dropped", 32'(len), 0);
    chk("R6 standby kept", 32'(sAfter), 1);
    writeProt(8'hFF);
    readCmd(OP_PROT_RD, rd, oe);
    chk("R7 write refused with wp low", 32'(rd), 32'hA5);
    sel(); sendBits(32'(OP_PROT_EN), 8); desel();
    readCmd(OP_STATUS, rd, oe);
    chk("R8 protection enable with wp low", 32'(rd), 32'h81);
    sel(); sendBits(32'(OP_LOCK), 8); sendBits(32'h00C00000, 24); desel();
    wpN = 1'b1;

    // R9: sweep sectors against two patterns, sector 6 locked
    pat = 8'hA5;
    for (int s = 0; s < 8; s++) begin
      peCmd(OP_PROG, {3'(s), 21'h0ABCD}, len, sBad, sAfter);
      chk($sformatf("R9 program sector %0d", s), 32'(len),
          (pat[s] || s == 6) ? 0 : 32'(BUSY));
    end
    writeProt(8'h5A);
    pat = 8'h5A;
    for (int s = 0; s < 8; s++) begin
      peCmd(OP_ERASE, {3'(s), 21'h1FFFFF}, len, sBad, sAfter);
      chk($sformatf("R9 erase sector %0d", s), 32'(len),
          (pat[s] || s == 6) ? 0 : 32'(BUSY));
    end

    // R10: reset aborts busy and read
    sel(); sendBits(32'(OP_PROG), 8); sendBits(32'h000100, 24); desel();
    chk("R10 busy before reset", 32'(busy), 1);
    rstN = 1'b0; tick(1);
    chk("R10 busy cleared", 32'(busy), 0);
    rstN = 1'b1; tick(2);
    sel(); sendBits(32'(OP_STATUS), 8); tick(1);
    chk("R4 soOe before reset", 32'(soOe), 1);
    rstN = 1'b0; tick(1);
    chk("R10 soOe cleared", 32'(soOe), 0);
    sendBits(32'(OP_PROT_EN), 8);
    chk("R10 no busy in reset", 32'(busy), 0);
    csN = 1'b1; tick(2); rstN = 1'b1; tick(2);
    readCmd(OP_STATUS, rd, oe);
    chk("R10 no command during reset", 32'(rd), 32'h80);

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule